// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a free-running watchdog counter. A slow timebase delivers one `tick` pulse per 100 ms step. Software programs a 5-bit timeout code and an enable bit in a control register. The count is restarted only when a fixed 4-bit key is written to the low nibble of a status register. That key write is also the only moment at which a newly programmed timeout code reaches the counter.

When the count runs out, the block always latches a sticky fault flag. It also emits a one-cycle reset request, but only if the enable bit is set. Two conditions restart the counter on their own: the end of a system reset pulse (`rst_release`) and a low supply. While the supply is reported low, the watchdog is held idle.

Register access uses a single byte-wide port. Writes happen on the clock edge. Reads are combinational and follow `addr`.

Top module: `keyed_wdt`

## Requirements
- R1: After `rst_n` is released, `fault_flag` and `reset_req` are 0. The control register (address 0x0A) reads 0x1F, which means the disabled code is loaded. The status register (address 0x09) reads 0x00.
- R2: A write to address 0x0A stores all 8 bits, and reading it returns them unchanged. Bit 7 is the enable bit and bits 4..0 are the timeout code. Reading 0x09 returns the fault flag in bit 7 and 0 in bits 6..0, so the key nibble always reads 0. Any other address reads 0.
- R3: After a key restart that loads code N (1..30), the N-th following tick is the expiry tick. `fault_flag` is 1 from the clock edge that samples that tick.
- R4: After expiry the counter starts again from zero with the same limit. The next expiry comes N ticks later.
- R5: With enable bit 7 = 1, `reset_req` is high for exactly the one cycle after the edge that samples the expiry tick.
- R6: With enable bit 7 = 0, expiry still sets `fault_flag` but `reset_req` stays 0.
- R7: While the loaded code is 31 (all ones), the counter never advances and no expiry ever occurs.
- R8: The key is written to address 0x09. Only the value 0b1010 in bits 3..0 restarts the count and loads the code. Any other nibble leaves the count and the loaded code unchanged.
- R9: A new timeout code written to 0x0A has no effect on expiry until the next key restart.
- R10: A one-cycle `rst_release` pulse restarts the count from zero and keeps the loaded code.
- R11: While `supply_ok` is 0, the count is held at zero. No expiry occurs and key writes are ignored. Counting resumes from zero once the supply is good.
- R12: Writing 0x09 with bit 7 = 0 clears `fault_flag`, and writing it with bit 7 = 1 leaves the flag as it is. If an expiry happens in the same cycle as a clear, the expiry wins.
- R13: A loaded code of 0 behaves like code 1, so every tick is an expiry tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase step pulse |
| supply_ok | input | 1 | High while supply is above the trip point |
| rst_release | input | 1 | One-cycle pulse at the end of a system reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| fault_flag | output | 1 | Sticky expiry flag |
| reset_req | output | 1 | One-cycle reset request on an enabled expiry |

## Verification
Register reads are combinational, so `rd_data` is due in the same cycle as `addr`. A write shows in the read data after the edge that samples it. The expiry is decided in the cycle where the final tick is presented. `fault_flag` and `reset_req` both change at that edge and are due one cycle after the tick was driven. A key write, a release pulse or a supply drop clears the count at its own edge, so the next tick already counts as tick one. The bench drives every input at the falling edge and steps its reference model at the rising edge. It compares flag, request and read data at the next falling edge, which is exactly one register stage after the stimulus.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int CODE_W = 5;
  localparam int KEY_W  = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int EN_BIT = 7;
  localparam int FLAG_BIT = 7;
  localparam int CLR_BIT = 7;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [DATA_W-1:0] byte_t;

  // limit in ticks for a loaded code: zero is promoted to one
  function automatic code_t tick_limit(input code_t c);
    return (c == '0) ? code_t'(1) : c;
  endfunction

  // all-ones code parks the counter
  function automatic logic code_parked(input code_t c);
    return &c;
  endfunction

  // next-count arithmetic: wraps to zero on the final tick
  function automatic code_t count_next(input code_t cnt, input code_t c);
    return (cnt == tick_limit(c) - code_t'(1)) ? '0 : cnt + code_t'(1);
  endfunction

  function automatic logic is_final_tick(input code_t cnt, input code_t c);
    return cnt == tick_limit(c) - code_t'(1);
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h09,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0A,
  parameter logic [KEY_W-1:0]  KEY      = 4'b1010,
  parameter byte_t             CTRL_RST = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  input  logic              fault_flag,
  output byte_t             ctrl_q,
  output logic              key_hit,
  output logic              flag_clr,
  output byte_t             rd_data
);
  logic stat_sel, ctrl_sel;

  assign stat_sel = wr_en && (addr == STAT_ADDR);
  assign ctrl_sel = wr_en && (addr == CTRL_ADDR);
  assign key_hit  = stat_sel && (wdata[KEY_W-1:0] == KEY);
  assign flag_clr = stat_sel && !wdata[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= CTRL_RST;
    else if (ctrl_sel) ctrl_q <= wdata;
  end

  // status byte: flag in its bit, every other bit reads zero
  byte_t stat_view;
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_stat
      if (gi == FLAG_BIT) begin : g_flag
        assign stat_view[gi] = fault_flag;
      end else begin : g_zero
        assign stat_view[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (addr == STAT_ADDR)      rd_data = stat_view;
    else if (addr == CTRL_ADDR) rd_data = ctrl_q;
    else                        rd_data = '0;
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter code_t LOAD_RST = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  supply_ok,
  input  logic  key_hit,
  input  logic  rst_release,
  input  code_t code_in,
  output code_t count_q,
  output code_t loaded_q,
  output logic  restart,
  output logic  expire
);
  logic key_ok, parked, step;

  assign key_ok  = supply_ok && key_hit;
  assign restart = supply_ok && (key_hit || rst_release);
  assign parked  = code_parked(loaded_q);
  assign step    = supply_ok && !restart && !parked && tick;
  assign expire  = step && is_final_tick(count_q, loaded_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= LOAD_RST;
    end else if (key_ok) begin
      loaded_q <= code_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= '0;
    else if (!supply_ok)     count_q <= '0;
    else if (restart)        count_q <= '0;
    else if (step)           count_q <= count_next(count_q, loaded_q);
  end
endmodule

// File: rtl/kwd_fault.sv
module kwd_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic enable,
  input  logic flag_clr,
  output logic fault_flag,
  output logic reset_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_flag <= 1'b0;
    else if (expire)   fault_flag <= 1'b1;
    else if (flag_clr) fault_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= expire && enable;
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h09,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0A,
  parameter logic [KEY_W-1:0]  KEY      = 4'b1010,
  parameter byte_t             CTRL_RST = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              supply_ok,
  input  logic              rst_release,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault_flag,
  output logic              reset_req
);
  localparam code_t LOAD_RST = CTRL_RST[CODE_W-1:0];

  byte_t ctrl_q;
  logic  key_hit, flag_clr, restart, expire, wd_enable;
  code_t count_q, loaded_q, code_field;

  assign code_field = ctrl_q[CODE_W-1:0];
  assign wd_enable  = ctrl_q[EN_BIT];

  kwd_regs #(
    .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR), .KEY(KEY), .CTRL_RST(CTRL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .fault_flag(fault_flag), .ctrl_q(ctrl_q), .key_hit(key_hit),
    .flag_clr(flag_clr), .rd_data(rd_data)
  );

  kwd_counter #(.LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .key_hit(key_hit), .rst_release(rst_release), .code_in(code_field),
    .count_q(count_q), .loaded_q(loaded_q), .restart(restart), .expire(expire)
  );

  kwd_fault u_fault (
    .clk(clk), .rst_n(rst_n), .expire(expire), .enable(wd_enable),
    .flag_clr(flag_clr), .fault_flag(fault_flag), .reset_req(reset_req)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  supply_ok,
  input logic  expire,
  input logic  restart,
  input logic  wd_enable,
  input logic  fault_flag,
  input logic  reset_req,
  input code_t count_q,
  input code_t loaded_q
);
  // R5 / R6: a request needs an expiry with the enable bit set one cycle earlier
  assert_req_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(expire && wd_enable));

  assert_no_req_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wd_enable) |=> !reset_req);

  // R3: flag only rises after an expiry
  assert_flag_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> $past(expire));

  // R12: expiry always leaves the flag set
  assert_expiry_sets_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> fault_flag);

  // R7: parked code never expires
  assert_parked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    code_parked(loaded_q) |-> !expire);

  // R11: low supply keeps the watchdog idle
  assert_supply_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (count_q == '0));

  assert_supply_no_expire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !expire);

  // R10 / R8: restart zeroes the count
  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == '0));

  // R4: count stays below the limit of the loaded code
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    code_parked(loaded_q) || (count_q < tick_limit(loaded_q)));
endmodule

bind keyed_wdt kwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .expire(expire),
  .restart(restart), .wd_enable(wd_enable), .fault_flag(fault_flag),
  .reset_req(reset_req), .count_q(count_q), .loaded_q(loaded_q)
);

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, supply_ok = 1'b1, rst_release = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rd_data;
  logic       fault_flag, reset_req;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  keyed_wdt uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .rst_release(rst_release), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .fault_flag(fault_flag), .reset_req(reset_req)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_ctrl;
  logic [4:0] m_loaded;
  int         m_cnt;
  logic       m_flag, m_req;

  function automatic int limit_of(input logic [4:0] c);
    if (c == 5'd0) return 1;
    return int'(c);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h09) return {m_flag, 7'b0};
    if (a == 8'h0A) return m_ctrl;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 8'h1F; m_loaded = 5'h1F; m_cnt = 0; m_flag = 0; m_req = 0;
    end else begin
      logic key, rs, ex;
      key = supply_ok && wr_en && addr == 8'h09 && wdata[3:0] == 4'b1010;
      rs  = supply_ok && (key || rst_release);
      ex  = 0;
      if (!supply_ok || rs) m_cnt = 0;
      else if (m_loaded != 5'h1F && tick) begin
        if (m_cnt + 1 >= limit_of(m_loaded)) begin ex = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      m_req = ex && m_ctrl[7];
      if (ex) m_flag = 1;
      else if (wr_en && addr == 8'h09 && !wdata[7]) m_flag = 0;
      if (key) m_loaded = m_ctrl[4:0];
      if (wr_en && addr == 8'h0A) m_ctrl = wdata;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive inputs at a falling edge, compare the outputs, wait for the next one
  task automatic step(input logic t, input logic we, input logic [7:0] a,
                      input logic [7:0] d, input logic rel, input logic sup);
    tick = t; wr_en = we; addr = a; wdata = d; rst_release = rel; supply_ok = sup;
    #0.5;
    chk("flag", {7'b0, fault_flag}, {7'b0, m_flag});
    chk("req",  {7'b0, reset_req},  {7'b0, m_req});
    chk("read", rd_data, exp_read(a));
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h09, 8'h00, 0, 1);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 8'h09, 8'h00, 0, 1);
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(0, 1, a, d, 0, 1);
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    tag = "R1";
    #0.5;
    chk("flag", {7'b0, fault_flag}, 8'h00);
    chk("req", {7'b0, reset_req}, 8'h00);
    addr = 8'h0A; #0.5; chk("ctrl", rd_data, 8'h1F);
    addr = 8'h09; #0.5; chk("stat", rd_data, 8'h00);
    @(negedge clk);

    // R7: parked code after reset never expires
    tag = "R7"; ticks(40);
    chk("parked flag", {7'b0, fault_flag}, 8'h00);

    // R2: control register round trip, other addresses read zero
    tag = "R2";
    wr(8'h0A, 8'h65); step(0, 0, 8'h0A, 0, 0, 1); chk("ctrl rd", rd_data, 8'h65);
    step(0, 0, 8'h33, 0, 0, 1); chk("unmapped", rd_data, 8'h00);

    // R3 / R5: enabled, code 3, expiry on the third tick
    tag = "R3"; wr(8'h0A, 8'h83); wr(8'h09, 8'h0A);
    ticks(2); chk("before", {7'b0, fault_flag}, 8'h00);
    tag = "R5"; step(1, 0, 8'h09, 0, 0, 1);
    #0.5; chk("req pulse", {7'b0, reset_req}, 8'h01);
    chk("flag set", {7'b0, fault_flag}, 8'h01);
    idle(1); chk("req drops", {7'b0, reset_req}, 8'h00);

    // R12: clear with bit7=1 keeps, bit7=0 clears
    tag = "R12"; wr(8'h09, 8'h80); chk("kept", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h00); chk("cleared", {7'b0, fault_flag}, 8'h00);

    // R4: reloads and expires again after 3 more ticks
    tag = "R4"; ticks(3); chk("second", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h00);

    // R12: expiry and clear together -> expiry wins
    tag = "R12"; ticks(2); step(1, 1, 8'h09, 8'h00, 0, 1);
    chk("expiry wins", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h00);

    // R6: disabled, flag only
    tag = "R6"; wr(8'h0A, 8'h02); wr(8'h09, 8'h0A); ticks(2);
    chk("flag", {7'b0, fault_flag}, 8'h01);
    chk("no req", {7'b0, reset_req}, 8'h00);
    wr(8'h09, 8'h00);

    // R8: wrong key does not restart
    tag = "R8"; wr(8'h0A, 8'h84); wr(8'h09, 8'h0A); ticks(3);
    wr(8'h09, 8'h05); step(1, 0, 8'h09, 0, 0, 1);
    chk("no restart", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h00);

    // R9: new code pending until key
    tag = "R9"; wr(8'h0A, 8'h81); ticks(3);
    chk("old limit", {7'b0, fault_flag}, 8'h00);
    ticks(1); chk("old expiry", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h0A); wr(8'h09, 8'h00); ticks(1);
    chk("new limit", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h00);

    // R10: release pulse restarts count
    tag = "R10"; wr(8'h0A, 8'h83); wr(8'h09, 8'h0A); ticks(2);
    step(0, 0, 8'h09, 0, 1, 1); ticks(2);
    chk("held off", {7'b0, fault_flag}, 8'h00);
    ticks(1); chk("expiry", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h00);

    // R11: supply low holds idle and ignores key
    tag = "R11"; ticks(2);
    for (int i = 0; i < 5; i++) step(1, 0, 8'h09, 0, 0, 0);
    step(0, 1, 8'h09, 8'h0A, 0, 0);
    chk("idle", {7'b0, fault_flag}, 8'h00);
    ticks(2); chk("from zero", {7'b0, fault_flag}, 8'h00);
    ticks(1); chk("resumed", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h00);

    // R13: code 0 behaves as 1
    tag = "R13"; wr(8'h0A, 8'h80); wr(8'h09, 8'h0A); ticks(1);
    chk("every tick", {7'b0, fault_flag}, 8'h01);
    wr(8'h09, 8'h00);

    // R7: parked code loaded by key
    tag = "R7"; wr(8'h0A, 8'h9F); wr(8'h09, 8'h0A); ticks(50);
    chk("parked", {7'b0, fault_flag}, 8'h00);

    // random mix, compared against the model every cycle
    tag = "R3";
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [7:0] a, d;
      r = int'($urandom_range(0, 99));
      a = ($urandom_range(0, 1) != 0) ? 8'h09 : 8'h0A;
      d = 8'($urandom());
      if (r < 3)       step(1, 1, 8'h0A, {d[7], 2'b00, 5'($urandom_range(0, 6))}, 0, 1);
      else if (r < 8)  step(($urandom_range(0,1) != 0), 1, 8'h09, {d[7], 3'b0, 4'b1010}, 0, 1);
      else if (r < 12) step(1, 1, a, d, 0, 1);
      else if (r < 14) step(1, 0, a, 8'h00, 1, 1);
      else if (r < 16) step(1, 0, a, 8'h00, 0, 0);
      else             step(($urandom_range(0, 2) != 0), 0, a, 8'h00, 0, 1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule